// File: doc/BRIEF.md
# Falling-Pair Serial Recognizer

This block watches a one-bit serial stream, sampled on each rising clock edge, and flags every place where a `1` is directly followed by a `0`. Two recognizers run side by side on the same input. One is a three-state machine whose flag depends only on its stored state. The other is a two-state machine whose flag is formed from its stored state and the live input bit. Both flags are available at once, so the fixed one-cycle lead of the input-dependent flag over the state-only flag can be observed at the pins.

A single parameter selects how the states are stored: as dense binary codes or with one flip-flop per state. The port behaviour is the same for either choice. Reset is asynchronous and active low. Occurrences that overlap are each reported.

Top module: `bitpair_detector`

## Requirements
- R1: While `rst_n` is low, both `moore_hit` and `mealy_hit` are 0 at once, with no clock edge needed. After release, both machines start from the empty state, so no detection involves any bit taken in before the reset.
- R2: `moore_hit` is 1 during a clock cycle exactly when the last two bits clocked in since reset were `1` and then `0`, with the `0` taken at the edge that starts the cycle.
- R3: `moore_hit` does not change when `din` changes between clock edges.
- R4: `mealy_hit` is 1 exactly when the last bit clocked in since reset was `1` and the present value of `din` is `0`.
- R5: From the second clock edge after reset onward, `moore_hit` in each cycle equals the value `mealy_hit` had just before the edge that started the cycle.
- R6: Overlapping occurrences are all reported. The stream 1,0,1,0,0 gives two pulses on each output.
- R7: With `ONE_HOT` = 0 the states are stored as binary codes (empty = 00, one seen = 01, pair seen = 10 for the three-state machine). With `ONE_HOT` = 1 each state has one flip-flop and exactly one of them is set. Both settings give identical outputs for any input stream, and the stored state is always a legal code.
- R8: A run of several `1` bits followed by one `0` gives exactly one pulse on each output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state is taken on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial data bit |
| moore_hit | output | 1 | Detect flag from stored state only |
| mealy_hit | output | 1 | Detect flag from stored state and live input |

## Verification
If the two-state machine holds a wrong state, the next `0` on `din` either shows a false `mealy_hit` or misses one in that same cycle. Since its single stored bit is also checked against the previously clocked input, the fault is caught at the next edge. A wrong state in the three-state machine shows on `moore_hit` one cycle later than the same error would on the Mealy side, and it breaks the fixed one-cycle relation between the two flags. A stored code outside the legal set is flagged in the cycle in which it appears, and it returns to the empty state at the next edge.

// File: rtl/bitpair_pkg.sv
package bitpair_pkg;

  // Width of the stored state for a machine with nstates states.
  function automatic int state_width(bit one_hot, int nstates);
    if (one_hot) return nstates;
    return (nstates > 2) ? 2 : 1;
  endfunction

  // Code of state number idx (0 = empty).
  function automatic logic [2:0] state_code(bit one_hot, int idx);
    if (one_hot) return 3'b001 << idx;
    return idx[2:0];
  endfunction

  // True when code is one of the nstates legal codes.
  function automatic logic code_legal(bit one_hot, logic [2:0] code, int nstates);
    if (one_hot) return $onehot(code);
    return (int'(code) < nstates);
  endfunction

endpackage

// File: rtl/bitpair_moore.sv
module bitpair_moore
  import bitpair_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit,
  output logic seen_one,
  output logic code_ok
);

  localparam int NST = 3;
  localparam int W   = state_width(ONE_HOT, NST);
  localparam logic [W-1:0] C_EMPTY = W'(state_code(ONE_HOT, 0));
  localparam logic [W-1:0] C_ONE   = W'(state_code(ONE_HOT, 1));
  localparam logic [W-1:0] C_PAIR  = W'(state_code(ONE_HOT, 2));

  logic [W-1:0] st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= C_EMPTY;
    else        st_q <= st_d;
  end

  always_comb begin
    case (st_q)
      C_EMPTY: st_d = din ? C_ONE : C_EMPTY;
      C_ONE:   st_d = din ? C_ONE : C_PAIR;
      C_PAIR:  st_d = din ? C_ONE : C_EMPTY;
      default: st_d = C_EMPTY;
    endcase
  end

  assign hit      = (st_q == C_PAIR);
  assign seen_one = (st_q == C_ONE);
  assign code_ok  = code_legal(ONE_HOT, 3'(st_q), NST);

endmodule

// File: rtl/bitpair_mealy.sv
module bitpair_mealy
  import bitpair_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic hit,
  output logic seen_one,
  output logic code_ok
);

  localparam int NST = 2;
  localparam int W   = state_width(ONE_HOT, NST);
  localparam logic [W-1:0] C_EMPTY = W'(state_code(ONE_HOT, 0));
  localparam logic [W-1:0] C_ONE   = W'(state_code(ONE_HOT, 1));

  logic [W-1:0] st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= C_EMPTY;
    else        st_q <= st_d;
  end

  always_comb begin
    case (st_q)
      C_EMPTY: st_d = din ? C_ONE : C_EMPTY;
      C_ONE:   st_d = din ? C_ONE : C_EMPTY;
      default: st_d = C_EMPTY;
    endcase
  end

  assign seen_one = (st_q == C_ONE);
  assign hit      = seen_one & ~din;
  assign code_ok  = code_legal(ONE_HOT, 3'(st_q), NST);

endmodule

// File: rtl/bitpair_detector.sv
module bitpair_detector #(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic moore_hit,
  output logic mealy_hit
);

  // Internal events brought out for the checker.
  logic moore_one;
  logic moore_ok;
  logic mealy_one;
  logic mealy_ok;

  bitpair_moore #(.ONE_HOT(ONE_HOT)) u_moore (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .hit      (moore_hit),
    .seen_one (moore_one),
    .code_ok  (moore_ok)
  );

  bitpair_mealy #(.ONE_HOT(ONE_HOT)) u_mealy (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .hit      (mealy_hit),
    .seen_one (mealy_one),
    .code_ok  (mealy_ok)
  );

endmodule

// File: rtl/bitpair_detector_chk.sv
module bitpair_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic moore_hit,
  input logic mealy_hit,
  input logic moore_one,
  input logic moore_ok,
  input logic mealy_one,
  input logic mealy_ok
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R5
  mealy_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (moore_hit == $past(mealy_hit)));

  // R4
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (mealy_one == $past(din)));

  // R4
  zero_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mealy_hit |-> !din);

  // R2
  no_double_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moore_hit |=> !moore_hit);

  // R2
  agree_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moore_one == mealy_one);

  // R7
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moore_ok && mealy_ok);

endmodule

bind bitpair_detector bitpair_detector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .moore_hit (moore_hit),
  .mealy_hit (mealy_hit),
  .moore_one (moore_one),
  .moore_ok  (moore_ok),
  .mealy_one (mealy_one),
  .mealy_ok  (mealy_ok)
);

// File: tb/test_bitpair_detector.sv
`timescale 1ns/100ps
module test_bitpair_detector;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic mo_b, me_b, mo_h, me_h;

  int checks = 0;
  int errors = 0;
  bit h1 = 0, h2 = 0;        // last and second-last clocked bits
  bit prev_me_b = 0, prev_me_h = 0;
  int cycles_since_rst = 0;
  int cnt_mo = 0, cnt_me = 0;

  always #2.5 clk = ~clk;

  bitpair_detector #(.ONE_HOT(1'b0)) i_bitpair_detector (
    .clk(clk), .rst_n(rst_n), .din(din), .moore_hit(mo_b), .mealy_hit(me_b));

  bitpair_detector #(.ONE_HOT(1'b1)) i_bitpair_detector_oh (
    .clk(clk), .rst_n(rst_n), .din(din), .moore_hit(mo_h), .mealy_hit(me_h));

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // Drive one bit just after a rising edge, check mid-cycle, advance.
  task automatic step(input bit b, input bit wiggle);
    bit exp_mo, exp_me;
    din = b;
    exp_me = h1 & ~b;
    exp_mo = h2 & ~h1;
    @(negedge clk);
    chk(mo_b, exp_mo, "R2", "moore binary");
    chk(me_b, exp_me, "R4", "mealy binary");
    chk(mo_h, exp_mo, "R2", "moore one-hot");
    chk(me_h, exp_me, "R4", "mealy one-hot");
    chk(mo_h, mo_b, "R7", "moore encodings agree");
    chk(me_h, me_b, "R7", "mealy encodings agree");
    if (cycles_since_rst >= 2) begin
      chk(mo_b, prev_me_b, "R5", "moore vs earlier mealy binary");
      chk(mo_h, prev_me_h, "R5", "moore vs earlier mealy one-hot");
    end
    if (mo_b) cnt_mo++;
    if (me_b) cnt_me++;
    prev_me_b = me_b;
    prev_me_h = me_h;
    if (wiggle) begin
      #0.5 din = ~b;
      #0.5;
      chk(mo_b, exp_mo, "R3", "moore binary with din flipped");
      chk(mo_h, exp_mo, "R3", "moore one-hot with din flipped");
      din = b;
    end
    @(posedge clk);
    h2 = h1;
    h1 = b;
    cycles_since_rst++;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #0.5;
    chk(mo_b, 1'b0, "R1", "moore binary in reset");
    chk(me_b, 1'b0, "R1", "mealy binary in reset");
    chk(mo_h, 1'b0, "R1", "moore one-hot in reset");
    chk(me_h, 1'b0, "R1", "mealy one-hot in reset");
    @(negedge clk);
    rst_n = 1'b1;
    h1 = 0; h2 = 0;
    prev_me_b = 0; prev_me_h = 0;
    cycles_since_rst = 0;
    @(posedge clk);
    cycles_since_rst = 1;
    #1;
  endtask

  initial begin
    #1;
    do_reset();
    // R1: empty state after reset: a lone 0 is not a detection
    step(0, 1);
    step(1, 1);
    step(0, 1);
    // Moore now shows the pair; reset mid-cycle must clear both at once
    din = 1'b0;
    #0.5;
    chk(mo_b, 1'b1, "R2", "moore pulse before async reset");
    rst_n = 1'b0;
    #0.3;
    chk(mo_b, 1'b0, "R1", "moore binary cleared without clock");
    chk(mo_h, 1'b0, "R1", "moore one-hot cleared without clock");
    chk(me_b, 1'b0, "R1", "mealy binary cleared without clock");
    do_reset();
    step(0, 0);  // R1: the 1 taken before reset is forgotten
    chk(me_b, 1'b0, "R1", "no stale detection after reset");

    // R6 overlap: 1,0,1,0,0 -> two pulses each
    do_reset();
    cnt_mo = 0; cnt_me = 0;
    step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(0, 0);
    chk(cnt_me == 2, 1'b1, "R6", "mealy pulse count");
    chk(cnt_mo == 2, 1'b1, "R6", "moore pulse count");

    // R8 run of ones then a zero -> one pulse each
    do_reset();
    cnt_mo = 0; cnt_me = 0;
    step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    chk(cnt_me == 1, 1'b1, "R8", "mealy pulse count");
    chk(cnt_mo == 1, 1'b1, "R8", "moore pulse count");

    // Exhaustive sweep of all 8-bit patterns, streamed back to back
    do_reset();
    for (int v = 0; v < 256; v++)
      for (int k = 7; k >= 0; k--)
        step(v[k], (k == 3));

    // Random tail
    for (int n = 0; n < 2000; n++)
      step(1'($urandom), (n % 7 == 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule